// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out the four multi-register transfer forms of a 16-bit instruction set. The four forms are stack store (push), stack load (pop), store-multiple with increment and load-multiple with increment. A pipeline front end hands it the 16-bit opcode and the current value of the stack pointer or base register, then pulses `start`. The sequencer then moves one 32-bit word per memory handshake. It reads the registers to store through a register-file read port and writes loaded words through a register-file write port. At the end it writes the final address back to the stack pointer (register 13) or to the base register.

A pop can load one extra word into the program counter. The sequencer reports this on `pc_redirect`, with the target address (bit 0 cleared) on `pc_target`. The front end uses it to steer the next fetch. A push can store the link register (register 14) in the same way. Only one memory request is open at a time, and the memory paces each request with `mem_ready`.

Top module: `blk_xfer_seq`

## Requirements
- R1: Decode: opcode[15:12]=1011 with opcode[10:9]=10 is a stack form, where opcode[11]=0 means push and opcode[11]=1 means pop, and opcode[8] adds the link register (push) or the program counter (pop). Opcode[15:12]=1100 is a multiple form, where opcode[11]=0 means store and 1 means load, and opcode[10:8] is the base register number. In every form, bit k of opcode[7:0] selects register k (k=0..7).
- R2: Each access moves one 32-bit word. Consecutive addresses differ by 4. At most one request is open, and `mem_addr` and `mem_we` hold steady while `mem_req` is high and `mem_ready` is low.
- R3: Push starts at base-4 and moves down. When opcode[8]=1, register 14 is stored first at the highest address, and the listed registers follow from register 7 down to register 0. Afterwards register 13 holds the last address stored.
- R4: Pop starts at base and moves up, loading the listed registers from register 0 up to register 7. Afterwards register 13 holds the address just past the last word read.
- R5: A pop with opcode[8]=1 reads one more word after the listed registers. It raises `pc_redirect` for exactly the `done` cycle, with `pc_target` equal to that word with bit 0 cleared, and it writes no general register with that word.
- R6: Store-multiple stores the listed registers in ascending order from the base address, then writes base+4×count back to the base register.
- R7: Load-multiple loads the listed registers in ascending order from the base address. It writes the final address back to the base register only when the base register is not in the list. Otherwise the base register keeps the loaded word.
- R8: An empty list with opcode[8]=0 (or in a multiple form) makes no memory access and writes no register, and `done` rises in the cycle after `start` is accepted.
- R9: `done` is a one-cycle pulse in the cycle after the final handshake. The write-back happens in that same cycle.
- R10: A `start` received while `busy` is high is ignored.
- R11: A synchronous reset returns the sequencer to idle, drops any open request and clears `pc_redirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer with `opcode` and `base_in` |
| opcode | input | 16 | Transfer instruction |
| base_in | input | W | Current stack pointer or base register value |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_idx | output | 4 | Register-file read index for store data |
| rf_rd_data | input | W | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | W | Register-file write data |
| mem_req | output | 1 | Memory request open |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | W | Word address of the request |
| mem_wdata | output | W | Store data |
| mem_ready | input | 1 | Memory completes the open request this cycle |
| mem_rdata | input | W | Load data, valid with `mem_ready` |
| pc_redirect | output | 1 | Program counter is loaded, valid with `done` |
| pc_target | output | W | New program counter value |

## Verification
A load writes its register at the same edge where `mem_ready` is sampled. `done`, the base or stack-pointer write-back and `pc_redirect` all appear one edge after the final handshake. The write-back lands in the register file one edge after that. The bench drives inputs and samples outputs on the falling edge. It checks `done` and the redirect in the first falling-edge sample where `done` is high, and compares the register file, memory image and access order one cycle later. An empty transfer and a reset are checked in the first falling-edge sample after the edge that acts on them.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int W      = 32,
  parameter int SP_REG = 13,
  parameter int LR_REG = 14
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [15:0]  opcode,
  input  logic [W-1:0] base_in,
  output logic         busy,
  output logic         done,
  output logic [3:0]   rf_rd_idx,
  input  logic [W-1:0] rf_rd_data,
  output logic         rf_we,
  output logic [3:0]   rf_wr_idx,
  output logic [W-1:0] rf_wr_data,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ready,
  input  logic [W-1:0] mem_rdata,
  output logic         pc_redirect,
  output logic [W-1:0] pc_target
);
  localparam int LW   = 8;
  localparam int LIW  = $clog2(LW);
  localparam int STEP = W / 8;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;

  st_t            state;
  logic [LW-1:0]  rem, list0;
  logic           ext_pend, op_push, op_load, op_stack, empty_f;
  logic [2:0]     base_idx;
  logic [W-1:0]   addr;
  logic [LIW-1:0] lo_idx, hi_idx;

  wire is_stack = opcode[15:12] == 4'hB && opcode[10:9] == 2'b10;
  wire is_blk   = opcode[15:12] == 4'hC;
  wire accept   = start && state == S_IDLE && (is_stack || is_blk);
  wire no_xfer  = opcode[7:0] == '0 && !(is_stack && opcode[8]);

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = LW - 1; i >= 0; i--)
      if (rem[i]) lo_idx = LIW'(i);
    for (int i = 0; i < LW; i++)
      if (rem[i]) hi_idx = LIW'(i);
  end

  wire            cur_ext  = op_push ? ext_pend : (rem == '0 && ext_pend);
  wire [LIW-1:0]  cur_gpr  = op_push ? hi_idx : lo_idx;
  wire [LW-1:0]   rem_next = cur_ext ? rem : rem & ~(LW'(1) << cur_gpr);
  wire            ext_next = cur_ext ? 1'b0 : ext_pend;
  wire            last     = rem_next == '0 && !ext_next;
  wire            hs       = state == S_XFER && mem_ready;
  wire [W-1:0]    wb_addr  = op_push ? addr + W'(STEP) : addr;
  wire            wb_keep  = op_load && !op_stack && list0[base_idx];
  wire            wb_en    = state == S_DONE && !empty_f && !wb_keep;
  wire            ld_en    = hs && op_load && !cur_ext;

  assign busy      = state != S_IDLE;
  assign done      = state == S_DONE;
  assign mem_req   = state == S_XFER;
  assign mem_we    = !op_load;
  assign mem_addr  = addr;
  assign mem_wdata = rf_rd_data;
  assign rf_rd_idx = cur_ext ? 4'(LR_REG) : 4'(cur_gpr);

  assign rf_we      = ld_en || wb_en;
  assign rf_wr_idx  = ld_en ? 4'(cur_gpr) : (op_stack ? 4'(SP_REG) : 4'(base_idx));
  assign rf_wr_data = ld_en ? mem_rdata : wb_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      rem         <= '0;
      list0       <= '0;
      ext_pend    <= 1'b0;
      op_push     <= 1'b0;
      op_load     <= 1'b0;
      op_stack    <= 1'b0;
      empty_f     <= 1'b0;
      base_idx    <= '0;
      addr        <= '0;
      pc_redirect <= 1'b0;
      pc_target   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_stack <= is_stack;
          op_load  <= opcode[11];
          op_push  <= is_stack && !opcode[11];
          base_idx <= opcode[10:8];
          rem      <= opcode[7:0];
          list0    <= opcode[7:0];
          ext_pend <= is_stack && opcode[8];
          empty_f  <= no_xfer;
          addr     <= (is_stack && !opcode[11]) ? base_in - W'(STEP) : base_in;
          state    <= no_xfer ? S_DONE : S_XFER;
        end
        S_XFER: if (hs) begin
          rem      <= rem_next;
          ext_pend <= ext_next;
          addr     <= op_push ? addr - W'(STEP) : addr + W'(STEP);
          if (op_load && cur_ext) begin
            pc_redirect <= 1'b1;
            pc_target   <= mem_rdata & ~W'(1);
          end
          if (last) state <= S_DONE;
        end
        default: begin
          state       <= S_IDLE;
          pc_redirect <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int W = 32
)(
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic         rf_we,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic         mem_ready,
  input logic         pc_redirect
);
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_STEP_WORD: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready |=> !mem_req || mem_addr == $past(mem_addr) + W'(4)
                             || mem_addr == $past(mem_addr) - W'(4)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |-> done); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !rf_we && !done); // R10
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !rf_we); // R3
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !busy && !mem_req && !pc_redirect); // R11
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.W(W)) u_chk (.*);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst = 1'b1, start = 1'b0;
  logic [15:0]  opcode = '0;
  logic [W-1:0] base_in = '0;
  logic         busy, done, rf_we, mem_req, mem_we, pc_redirect;
  logic [3:0]   rf_rd_idx, rf_wr_idx;
  logic [W-1:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata, pc_target;
  logic         mem_ready = 1'b0;

  blk_xfer_seq u_dut (.*);

  logic [W-1:0] rf [16];
  logic [W-1:0] mem [64];
  logic [W-1:0] acc_addr [16];
  int           acc_n;
  logic         init_go = 1'b0;
  logic [3:0]   init_idx = '0;
  logic [W-1:0] init_val = '0;
  int           wait_cfg = 0, wcnt = 0;

  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_rdata  = mem[mem_addr[7:2]];

  function automatic logic [W-1:0] rf_seed(int k);
    return 32'h5000_0000 + k * 32'h0101;
  endfunction
  function automatic logic [W-1:0] mem_seed(int k);
    return 32'hC0DE_0001 | W'(k << 2);
  endfunction

  always @(posedge clk) begin
    if (init_go) begin
      for (int k = 0; k < 16; k++) rf[k] <= (4'(k) == init_idx) ? init_val : rf_seed(k);
      for (int k = 0; k < 64; k++) mem[k] <= mem_seed(k);
      acc_n <= 0;
    end else begin
      if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
      if (mem_req && mem_ready) begin
        if (acc_n < 16) acc_addr[acc_n] <= mem_addr;
        acc_n <= acc_n + 1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0; wcnt <= 0;
    end else if (mem_req && !mem_ready) begin
      if (wcnt >= wait_cfg) begin mem_ready <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else mem_ready <= 1'b0;
  end

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [W-1:0] exp_rf [16];
  logic [W-1:0] exp_mem [64];
  logic [W-1:0] exp_addr [16];
  int           exp_n;
  logic         exp_pcv;
  logic [W-1:0] exp_pc;

  task automatic model(input logic [15:0] op, input logic [W-1:0] base);
    logic stk, ld, ext, push;
    logic [2:0] b;
    logic [W-1:0] a;
    stk = op[15:12] == 4'hB; ld = op[11]; ext = stk && op[8];
    push = stk && !ld; b = op[10:8];
    for (int k = 0; k < 16; k++) exp_rf[k] = rf_seed(k);
    exp_rf[stk ? 13 : int'(b)] = base;
    for (int k = 0; k < 64; k++) exp_mem[k] = mem_seed(k);
    exp_n = 0; exp_pcv = 1'b0; exp_pc = '0; a = base;
    if (push) begin
      if (ext) begin a -= 4; exp_addr[exp_n++] = a; exp_mem[a[7:2]] = exp_rf[14]; end
      for (int i = 7; i >= 0; i--)
        if (op[i]) begin a -= 4; exp_addr[exp_n++] = a; exp_mem[a[7:2]] = exp_rf[i]; end
      if (exp_n > 0) exp_rf[13] = a;
    end else begin
      logic [W-1:0] old_rf [16];
      for (int k = 0; k < 16; k++) old_rf[k] = exp_rf[k];
      for (int i = 0; i < 8; i++)
        if (op[i]) begin
          exp_addr[exp_n++] = a;
          if (ld) exp_rf[i] = exp_mem[a[7:2]]; else exp_mem[a[7:2]] = old_rf[i];
          a += 4;
        end
      if (ext) begin
        exp_addr[exp_n++] = a; exp_pcv = 1'b1; exp_pc = exp_mem[a[7:2]] & ~W'(1); a += 4;
      end
      if (exp_n > 0) begin
        if (stk) exp_rf[13] = a;
        else if (!(ld && op[b])) exp_rf[b] = a;
      end
    end
  endtask

  task automatic prime(input logic [15:0] op, input logic [W-1:0] base, input int wt);
    @(negedge clk);
    init_idx = (op[15:12] == 4'hB) ? 4'd13 : {1'b0, op[10:8]};
    init_val = base; init_go = 1'b1; wait_cfg = wt;
    @(negedge clk);
    init_go = 1'b0;
  endtask

  task automatic launch(input logic [15:0] op, input logic [W-1:0] base);
    start = 1'b1; opcode = op; base_in = base;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
  endtask

  // opcode, base, memory wait cycles, expected access count
  localparam logic [63:0] VEC [9] = '{
    {16'hB485, 32'h0000_0080, 8'd1, 8'd3},
    {16'hB502, 32'h0000_0080, 8'd0, 8'd2},
    {16'hBC18, 32'h0000_0040, 8'd2, 8'd2},
    {16'hBD01, 32'h0000_0040, 8'd0, 8'd2},
    {16'hC543, 32'h0000_0020, 8'd3, 8'd3},
    {16'hCA0A, 32'h0000_0060, 8'd1, 8'd2},
    {16'hCB18, 32'h0000_0060, 8'd0, 8'd2},
    {16'hB400, 32'h0000_0080, 8'd0, 8'd0},
    {16'hB5FF, 32'h0000_0080, 8'd1, 8'd9}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", W'(busy), 0);
    chk("R11 reset req", W'(mem_req), 0);
    chk("R11 reset redirect", W'(pc_redirect), 0);
    chk("R9 reset done", W'(done), 0);

    for (int v = 0; v < 9; v++) begin
      logic [15:0] op;
      logic [W-1:0] base;
      op = VEC[v][63:48]; base = VEC[v][47:16];
      model(op, base);
      prime(op, base, int'(VEC[v][15:8]));
      launch(op, base);
      wait_done();
      chk($sformatf("R9 v%0d done", v), W'(done), 1);
      chk($sformatf("R5 v%0d redirect", v), W'(pc_redirect), W'(exp_pcv));
      if (exp_pcv) chk($sformatf("R5 v%0d target", v), pc_target, exp_pc);
      @(negedge clk);
      chk($sformatf("R9 v%0d done pulse", v), W'(done), 0);
      chk($sformatf("R2 v%0d count", v), W'(acc_n), W'(VEC[v][7:0]));
      chk($sformatf("R1 v%0d model count", v), W'(acc_n), W'(exp_n));
      for (int k = 0; k < exp_n && k < 16; k++)
        chk($sformatf("R3 R4 R6 R7 v%0d addr%0d", v, k), acc_addr[k], exp_addr[k]);
      for (int k = 0; k < 16; k++)
        chk($sformatf("R4 R7 v%0d rf%0d", v, k), rf[k], exp_rf[k]);
      for (int k = 0; k < 64; k++)
        if (mem[k] !== exp_mem[k]) chk($sformatf("R3 R6 v%0d mem%0d", v, k), mem[k], exp_mem[k]);
    end

    // R8: empty list finishes in the next cycle without touching anything
    prime(16'hB400, 32'h80, 0);
    launch(16'hB400, 32'h80);
    chk("R8 empty done next", W'(done), 1);
    @(negedge clk);
    chk("R8 empty no access", W'(acc_n), 0);
    chk("R8 empty sp kept", rf[13], 32'h80);
    chk("R8 empty idle", W'(busy), 0);

    // R10: a second start during a transfer is ignored
    prime(16'hB401, 32'h80, 5);
    launch(16'hB401, 32'h80);
    launch(16'hBCFF, 32'h40);
    wait_done();
    @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R10 ignored start count", W'(acc_n), 1);
    chk("R10 ignored start sp", rf[13], 32'h7C);
    chk("R10 idle after", W'(busy), 0);

    // R11: reset during an open request
    prime(16'hBD01, 32'h40, 6);
    launch(16'hBD01, 32'h40);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 mid busy", W'(busy), 0);
    chk("R11 mid req", W'(mem_req), 0);
    chk("R11 mid redirect", W'(pc_redirect), 0);
    repeat (10) @(negedge clk);
    chk("R11 mid no access", W'(acc_n), 0);
    chk("R11 mid sp kept", rf[13], 32'h40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule